// File: doc/BRIEF.md
# Serial Audio Link Frame Timer

This block is the controller-side timing core of a serial audio link. It derives the link bit clock from its own clock, which runs at twice the bit rate. One clock cycle (a "tick") is one half of a bit-clock period, so the 48 kHz frame of 500 bit clocks is 1000 ticks long. The block drives the frame sync strobe. It shifts a 1000-bit outbound payload onto a single serial output, one new bit on every bit-clock edge. It captures 500 inbound bits per frame from a single serial input, sampled on bit-clock rising edges. It also drives an active-low link reset.

The link is isochronous. A frame goes out every period whether or not the payload buffer supplied data. Sixteen bit clocks before each frame boundary the block raises a one-cycle request so that the buffer can present the next payload. At the boundary the block takes that payload if it is marked valid. If it is not valid, the block sends zeros and flags an underrun. The inbound bits of each complete frame are delivered at the start of the following frame.

The sequencer has three states: `ST_LINK_RESET`, `ST_LEAD_IN` and `ST_ACTIVE`.
- A block reset, or a held link-reset request, moves the sequencer from any state to `ST_LINK_RESET`.
- Dropping the request moves `ST_LINK_RESET` to `ST_LEAD_IN`.
- `ST_LEAD_IN` runs one silent frame period. At its last tick it moves to `ST_ACTIVE`.
- `ST_ACTIVE` wraps from its last tick to the start of the next frame.

Top module: `slft_link_timer`

## Requirements
- R1: While `rst_n` is low, or one cycle after `link_rst_req_i` is sampled high, `link_rst_n_o`, `bclk_o`, `sync_o`, `sdo_o`, `tx_req_o`, `frame_start_o`, `underrun_o` and `rx_valid_o` are all 0, and `frame_cnt_o` is 0.
- R2: Outside link reset, the tick counter runs from 0 to 999 in each frame. `bclk_o` is 0 in even ticks and 1 in odd ticks, which gives 500 bit clocks per frame.
- R3: After the link-reset request is released, the first tick is tick 0 of a lead-in frame period. During the lead-in, `sync_o`, `sdo_o`, `frame_start_o` and `frame_cnt_o` stay 0. The first frame starts 1000 cycles after the first lead-in tick.
- R4: In an active frame, `sync_o` is 1 in ticks 992 to 999, which are the last 4 bit clocks. Each following frame therefore begins on the falling edge of `sync_o`.
- R5: `frame_start_o` is 1 exactly in tick 0 of every active frame. Frames follow each other every 1000 cycles regardless of payload readiness. `frame_cnt_o` is 0 in the first frame and increments by one at each later frame start.
- R6: `tx_req_o` is 1 for exactly tick 968 of every frame period (16 bit clocks before the boundary), including the lead-in.
- R7: `tx_data_i` and `tx_valid_i` are sampled only at the clock edge that ends tick 999. If valid, bit k of the payload appears on `sdo_o` during tick k of the next frame (bit 0 first). Input changes at other times have no effect.
- R8: If `tx_valid_i` is 0 at the boundary, `sdo_o` stays 0 for the whole frame and `underrun_o` is 1 for tick 0 of that frame only.
- R9: In active frames, `sdi_i` is sampled at the edge ending each even tick, which is a bit-clock rising edge. Bit j of `rx_data_o` is the sample taken at the end of tick 2j. The word is presented with a one-cycle `rx_valid_o` in tick 0 of the next frame. Lead-in and interrupted frames deliver nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low block reset |
| link_rst_req_i | input | 1 | Holds the link in reset while high |
| tx_data_i | input | 1000 | Outbound payload for the next frame, bit 0 sent first |
| tx_valid_i | input | 1 | Payload on `tx_data_i` is valid |
| sdi_i | input | 1 | Inbound serial data |
| bclk_o | output | 1 | Link bit clock |
| sync_o | output | 1 | Frame sync strobe |
| sdo_o | output | 1 | Outbound serial data, new bit every bit-clock edge |
| link_rst_n_o | output | 1 | Active-low link reset |
| tx_req_o | output | 1 | One-cycle payload request, 16 bit clocks before the boundary |
| frame_start_o | output | 1 | One-cycle pulse in the first tick of each frame |
| underrun_o | output | 1 | One-cycle pulse when a frame went out without payload |
| rx_data_o | output | 500 | Inbound bits of the last complete frame |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_data_o` is updated |
| frame_cnt_o | output | 16 | Frame number since the link left reset |

## Verification
All serial outputs, strobes and `link_rst_n_o` are decoded from registers, so each reflects an input one cycle after the edge that samples it. A link-reset request idles the link in the next tick. A payload appears from tick 0 of the frame after its boundary edge. Each `sdi_i` bit is presented on `rx_data_o` in tick 0 of the frame after the frame in which it was sampled. The bench advances its own model of state, tick and frame number before each rising edge, from the inputs driven for that edge. It compares every output at the following falling edge and changes inputs only after that comparison, so every check lands in the tick its result is due.

// File: rtl/slft_pkg.sv
package slft_pkg;

    typedef enum logic [1:0] {
        ST_LINK_RESET = 2'd0,
        ST_LEAD_IN    = 2'd1,
        ST_ACTIVE     = 2'd2
    } slft_state_e;

endpackage

// File: rtl/slft_frame_seq.sv
module slft_frame_seq
    import slft_pkg::*;
#(
    parameter int BCLK_PER_FRAME = 500,
    parameter int SYNC_BCLKS     = 4,
    parameter int REQ_LEAD_BCLKS = 16,
    parameter int FCNT_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_rst_req_i,
    output logic              bclk_o,
    output logic              sync_o,
    output logic              link_rst_n_o,
    output logic              tx_req_o,
    output logic              frame_start_o,
    output logic [FCNT_W-1:0] frame_cnt_o,
    output logic              in_active_o,
    output logic              clear_o,
    output logic              frame_wrap_o,
    output logic              sample_en_o,
    output logic              deliver_o
);

    localparam int TICKS      = 2 * BCLK_PER_FRAME;
    localparam int TW         = $clog2(TICKS);
    localparam logic [TW-1:0] LAST_T = TW'(TICKS - 1);
    localparam logic [TW-1:0] SYNC_T = TW'(TICKS - 2 * SYNC_BCLKS);
    localparam logic [TW-1:0] REQ_T  = TW'(TICKS - 2 * REQ_LEAD_BCLKS);

    slft_state_e       state_q, state_d;
    logic [TW-1:0]     tick_q, tick_d;
    logic [FCNT_W-1:0] fcnt_q;
    logic              at_last;

    assign at_last = (tick_q == LAST_T);

    // next-state process
    always_comb begin
        state_d = state_q;
        tick_d  = tick_q;
        if (link_rst_req_i) begin
            state_d = ST_LINK_RESET;
            tick_d  = '0;
        end else begin
            unique case (state_q)
                ST_LINK_RESET: begin
                    state_d = ST_LEAD_IN;
                    tick_d  = '0;
                end
                ST_LEAD_IN: begin
                    if (at_last) begin
                        state_d = ST_ACTIVE;
                        tick_d  = '0;
                    end else begin
                        tick_d = tick_q + 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    tick_d = at_last ? '0 : tick_q + 1'b1;
                end
                default: begin
                    state_d = ST_LINK_RESET;
                    tick_d  = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LINK_RESET;
            tick_q  <= '0;
            fcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            tick_q  <= tick_d;
            if (link_rst_req_i || state_q == ST_LINK_RESET)
                fcnt_q <= '0;
            else if (state_q == ST_ACTIVE && at_last)
                fcnt_q <= fcnt_q + 1'b1;
        end
    end

    // output process
    always_comb begin
        link_rst_n_o  = (state_q != ST_LINK_RESET);
        bclk_o        = link_rst_n_o && tick_q[0];
        sync_o        = (state_q == ST_ACTIVE) && (tick_q >= SYNC_T);
        frame_start_o = (state_q == ST_ACTIVE) && (tick_q == '0);
        tx_req_o      = link_rst_n_o && (tick_q == REQ_T);
        in_active_o   = (state_q == ST_ACTIVE);
        clear_o       = link_rst_req_i || (state_q == ST_LINK_RESET);
        frame_wrap_o  = !link_rst_req_i && link_rst_n_o && at_last;
        sample_en_o   = !link_rst_req_i && in_active_o && !tick_q[0];
        deliver_o     = !link_rst_req_i && in_active_o && at_last;
        frame_cnt_o   = fcnt_q;
    end

    assert_txreq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |=> !tx_req_o);

    assert_sync_fall_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_o) && link_rst_n_o) |-> frame_start_o);

    assert_bclk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rst_n_o && $past(link_rst_n_o)) |-> (bclk_o != $past(bclk_o)));

endmodule

// File: rtl/slft_tx_ser.sv
module slft_tx_ser #(
    parameter int TX_W = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            load_i,
    input  logic            shift_i,
    input  logic [TX_W-1:0] tx_data_i,
    input  logic            tx_valid_i,
    output logic            sdo_o,
    output logic            underrun_o
);

    logic [TX_W-1:0] sh_q;
    logic            und_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            und_q <= 1'b0;
        end else if (clear_i) begin
            sh_q  <= '0;
            und_q <= 1'b0;
        end else if (load_i) begin
            sh_q  <= tx_valid_i ? tx_data_i : '0;
            und_q <= !tx_valid_i;
        end else begin
            if (shift_i)
                sh_q <= sh_q >> 1;
            und_q <= 1'b0;
        end
    end

    assign sdo_o      = shift_i && sh_q[0];
    assign underrun_o = und_q;

    assert_underrun_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> !sdo_o);

endmodule

// File: rtl/slft_rx_cap.sv
module slft_rx_cap #(
    parameter int RX_W = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            sample_i,
    input  logic            deliver_i,
    input  logic            sdi_i,
    output logic [RX_W-1:0] rx_data_o,
    output logic            rx_valid_o
);

    logic [RX_W-1:0] sh_q;
    logic [RX_W-1:0] word_q;
    logic            vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            word_q <= '0;
            vld_q  <= 1'b0;
        end else if (clear_i) begin
            sh_q   <= '0;
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            if (sample_i)
                sh_q <= {sdi_i, sh_q[RX_W-1:1]};
            if (deliver_i)
                word_q <= sh_q;
            vld_q <= deliver_i;
        end
    end

    assign rx_data_o  = word_q;
    assign rx_valid_o = vld_q;

    assert_rxv_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

endmodule

// File: rtl/slft_link_timer.sv
module slft_link_timer #(
    parameter int BCLK_PER_FRAME = 500,
    parameter int SYNC_BCLKS     = 4,
    parameter int REQ_LEAD_BCLKS = 16,
    parameter int FCNT_W         = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          link_rst_req_i,
    input  logic [2*BCLK_PER_FRAME-1:0]   tx_data_i,
    input  logic                          tx_valid_i,
    input  logic                          sdi_i,
    output logic                          bclk_o,
    output logic                          sync_o,
    output logic                          sdo_o,
    output logic                          link_rst_n_o,
    output logic                          tx_req_o,
    output logic                          frame_start_o,
    output logic                          underrun_o,
    output logic [BCLK_PER_FRAME-1:0]     rx_data_o,
    output logic                          rx_valid_o,
    output logic [FCNT_W-1:0]             frame_cnt_o
);

    localparam int TX_W = 2 * BCLK_PER_FRAME;
    localparam int RX_W = BCLK_PER_FRAME;

    logic in_active, clear, frame_wrap, sample_en, deliver;

    slft_frame_seq #(
        .BCLK_PER_FRAME (BCLK_PER_FRAME),
        .SYNC_BCLKS     (SYNC_BCLKS),
        .REQ_LEAD_BCLKS (REQ_LEAD_BCLKS),
        .FCNT_W         (FCNT_W)
    ) seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .link_rst_req_i (link_rst_req_i),
        .bclk_o         (bclk_o),
        .sync_o         (sync_o),
        .link_rst_n_o   (link_rst_n_o),
        .tx_req_o       (tx_req_o),
        .frame_start_o  (frame_start_o),
        .frame_cnt_o    (frame_cnt_o),
        .in_active_o    (in_active),
        .clear_o        (clear),
        .frame_wrap_o   (frame_wrap),
        .sample_en_o    (sample_en),
        .deliver_o      (deliver)
    );

    slft_tx_ser #(.TX_W(TX_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .load_i     (frame_wrap),
        .shift_i    (in_active),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .sdo_o      (sdo_o),
        .underrun_o (underrun_o)
    );

    slft_rx_cap #(.RX_W(RX_W)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .sample_i   (sample_en),
        .deliver_i  (deliver),
        .sdi_i      (sdi_i),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o)
    );

    assert_idle_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_rst_n_o |-> !(bclk_o || sync_o || sdo_o || tx_req_o || underrun_o));

    assert_rxv_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> frame_start_o);

endmodule

// File: tb/slft_link_timer_tb_top.sv
module slft_link_timer_tb_top;

    localparam int NB    = 500;
    localparam int TICKS = 2 * NB;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            link_rst_req_i = 1'b1;
    logic [TICKS-1:0] tx_data_i = '0;
    logic            tx_valid_i = 1'b0;
    logic            sdi_i = 1'b0;
    logic            bclk_o, sync_o, sdo_o, link_rst_n_o, tx_req_o;
    logic            frame_start_o, underrun_o, rx_valid_o;
    logic [NB-1:0]   rx_data_o;
    logic [15:0]     frame_cnt_o;

    int checks = 0;
    int errors = 0;

    // bench model
    int               m_st = 0;   // 0 reset, 1 lead-in, 2 active
    int               m_tick = 0;
    int               m_frame = 0;
    bit               m_prev_act = 1'b0;
    logic [TICKS-1:0] cur_pl = '0, next_pl = '0;
    bit               cur_vld = 1'b0, next_vld = 1'b0;
    logic [NB-1:0]    rx_cur = '0, rx_prev = '0;
    int               req_num = 0;

    always #5 clk = ~clk;

    slft_link_timer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .link_rst_req_i (link_rst_req_i),
        .tx_data_i      (tx_data_i),
        .tx_valid_i     (tx_valid_i),
        .sdi_i          (sdi_i),
        .bclk_o         (bclk_o),
        .sync_o         (sync_o),
        .sdo_o          (sdo_o),
        .link_rst_n_o   (link_rst_n_o),
        .tx_req_o       (tx_req_o),
        .frame_start_o  (frame_start_o),
        .underrun_o     (underrun_o),
        .rx_data_o      (rx_data_o),
        .rx_valid_o     (rx_valid_o),
        .frame_cnt_o    (frame_cnt_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s tick=%0d act=%0h exp=%0h", tag, m_tick, act, exp);
        end
    endtask

    function automatic logic [TICKS-1:0] rand_payload();
        logic [TICKS-1:0] p;
        for (int i = 0; i < TICKS; i++) p[i] = 1'($urandom % 2);
        return p;
    endfunction

    // advance model across the coming rising edge
    task automatic advance();
        if (!rst_n || link_rst_req_i) begin
            m_st = 0; m_tick = 0; m_frame = 0; m_prev_act = 1'b0;
        end else if (m_st == 0) begin
            m_st = 1; m_tick = 0;
        end else if (m_tick == TICKS - 1) begin
            if (m_st == 2) begin
                m_frame++;
                rx_prev = rx_cur;
                m_prev_act = 1'b1;
            end else begin
                m_prev_act = 1'b0;
            end
            m_st = 2; m_tick = 0;
            cur_pl = next_pl; cur_vld = next_vld;
        end else begin
            m_tick++;
        end
    endtask

    task automatic check_now();
        bit act = (m_st == 2);
        bit run = (m_st != 0);
        bit e_sdo;
        chk(link_rst_n_o == run, "R1 link_rst_n", 64'(link_rst_n_o), 64'(run));
        chk(bclk_o == (run && m_tick[0]), "R2 bclk", 64'(bclk_o), 64'(run && m_tick[0]));
        chk(sync_o == (act && m_tick >= TICKS - 8), (m_st == 1) ? "R3 sync lead-in" : "R4 sync",
            64'(sync_o), 64'(act && m_tick >= TICKS - 8));
        chk(frame_start_o == (act && m_tick == 0), (m_st == 1) ? "R3 frame_start lead-in" : "R5 frame_start",
            64'(frame_start_o), 64'(act && m_tick == 0));
        chk(frame_cnt_o == 16'(m_frame), (m_st == 1) ? "R3 frame_cnt lead-in" : "R5 frame_cnt",
            64'(frame_cnt_o), 64'(16'(m_frame)));
        chk(tx_req_o == (run && m_tick == TICKS - 32), "R6 tx_req", 64'(tx_req_o), 64'(run && m_tick == TICKS - 32));
        e_sdo = act && cur_vld && cur_pl[m_tick];
        chk(sdo_o == e_sdo, (act && !cur_vld) ? "R8 sdo zero" : "R7 sdo", 64'(sdo_o), 64'(e_sdo));
        chk(underrun_o == (act && m_tick == 0 && !cur_vld), "R8 underrun",
            64'(underrun_o), 64'(act && m_tick == 0 && !cur_vld));
        chk(rx_valid_o == (act && m_tick == 0 && m_prev_act), "R9 rx_valid",
            64'(rx_valid_o), 64'(act && m_tick == 0 && m_prev_act));
        if (act && m_tick == 0 && m_prev_act)
            chk(rx_data_o == rx_prev, "R9 rx_data", rx_data_o[63:0], rx_prev[63:0]);
        if (!run)
            chk(!(sdo_o || underrun_o || rx_valid_o), "R1 idle", 64'({sdo_o, underrun_o, rx_valid_o}), 64'(0));
    endtask

    task automatic drive_data();
        bit b = 1'($urandom % 2);
        sdi_i = b;
        if (m_st == 2 && !m_tick[0]) rx_cur[m_tick / 2] = b;
        if (m_st == 2 && m_tick == 0) begin
            // garbage away from the boundary must be ignored (R7)
            tx_data_i  = rand_payload();
            tx_valid_i = 1'($urandom % 2);
        end
        if (m_st != 0 && m_tick == TICKS - 32) begin
            req_num++;
            case (req_num)
                3: begin next_vld = 1'b0; next_pl = rand_payload(); end
                4: begin next_vld = 1'b1; next_pl = '1; end
                5: begin next_vld = 1'b1; next_pl = '0; end
                default: begin next_vld = ($urandom % 4) != 0; next_pl = rand_payload(); end
            endcase
            tx_data_i  = next_pl;
            tx_valid_i = next_vld;
        end
    endtask

    task automatic step();
        advance();
        @(negedge clk);
        check_now();
        drive_data();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) step();
        rst_n = 1'b1;
        repeat (3) step();
        link_rst_req_i = 1'b0;
        repeat (6 * TICKS + 50) step();
        // interrupt an active frame mid-way
        while (m_tick != 300) step();
        link_rst_req_i = 1'b1;
        repeat (10) step();
        link_rst_req_i = 1'b0;
        repeat (3 * TICKS + 20) step();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule